// File: doc/BRIEF.md
# Legacy I/O Window Controller

This block sits between a processor bus and an 8 MB I/O aperture. It detects whether a processor address falls inside the aperture. It then turns the offset into a port address for the ISA-style devices downstream. Two decoding modes are available. The contiguous mode passes the offset through unchanged. The sparse mode keeps the five lowest byte-select bits and packs the page-number bits directly above them. This lets each 4 KB page of the window reach one group of 32 ports.

The block also holds a handful of byte-wide control registers, reached through a simple synchronous write and combinational read bus:

- a mode bit that selects the decoding,
- a 4-bit system control field,
- a reset-request port,
- a disk activity light bit,
- a set of fixed identification bytes.

A write to the mode bit changes the translation of the very next processor access. No pipeline register stands in the way.

Top module: `io_window_ctl`

## Requirements
- R1: `io_hit` is 1 exactly when `cpu_addr` lies in [0x8000_0000, 0x8080_0000). Outside that range `io_port` is 0.
- R2: With the mode bit at 0, `io_port` equals the 23-bit offset `cpu_addr - 0x8000_0000` unchanged.
- R3: With the mode bit at 1, `io_port` equals `(offset & 0x1F) | ((offset & 0x7FF000) >> 7)`. The result never sets a bit above bit 15.
- R4: The mode register at 0x080A stores only bit 0 of a written byte. A read returns 0x00 or 0x01.
- R5: The system control register at 0x0808 stores the low 4 bits of a written byte. A read returns them in bits 3:0, with bits 7:4 at 0.
- R6: A write to port 0x0092 sets `rst_req` to bit 0 of the byte. A read of 0x0092 returns `rst_req` in bit 0 and 0 elsewhere.
- R7: A write to 0x0809 sets `light` to bit 0 of the byte. A read of 0x0809 returns `light` in bit 0.
- R8: The read-only identification bytes are:

  | Address | Value |
  |---------|-------|
  | 0x0800 | 0xEF |
  | 0x0801 | 0xAD |
  | 0x0802 | 0xE0 |
  | 0x0803 | 0x39 |
  | 0x0804 | 0x03 |

- R9: A read of any other register address returns 0xFF. A write to such an address changes no state.
- R10: A write to an identification address is ignored. The byte still reads back its fixed value, and no other register changes.
- R11: After reset, the mode bit, system control field, `light` and `rst_req` are all 0.
- R12: A processor access presented in the cycle right after a mode-register write is translated with the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register port address |
| reg_we | input | 1 | Register write strobe, captured at the rising edge |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, combinational from `reg_addr` |
| cpu_addr | input | 32 | Processor-side address |
| io_hit | output | 1 | Address falls inside the I/O aperture |
| io_port | output | 23 | Translated port address |
| rst_req | output | 1 | Soft reset request |
| light | output | 1 | Disk activity light |

## Verification
The bound checker checks the following on every cycle:

- Each writable register takes the right bits of a write to its own address.
- No state moves in a cycle without a write.
- Addresses outside the aperture never produce a hit or a non-zero port.
- Sparse decoding never sets port bits above bit 15.
- The first identification byte always reads its fixed value.

Only the bench's scenarios can show the rest. These include the exact translated value of chosen addresses in both modes, and the aperture edges. They also include the mode switch taking effect on the next access, and undecoded and read-only writes leaving every readable register intact.

// File: rtl/io_window_ctl.sv
module io_window_ctl #(
  parameter int                 CPU_AW     = 32,
  parameter int                 APER_AW    = 23,
  parameter logic [CPU_AW-1:0]  APER_BASE  = 32'h8000_0000,
  parameter int                 SPARSE_LOW = 5,
  parameter int                 PAGE_LSB   = 12,
  parameter int                 REG_AW     = 16,
  parameter logic [REG_AW-1:0]  RST_PORT   = 16'h0092,
  parameter logic [REG_AW-1:0]  CTRL_BASE  = 16'h0800,
  parameter logic [7:0]         ID_CPUCFG  = 8'hEF,
  parameter logic [7:0]         ID_FEAT    = 8'hAD,
  parameter logic [7:0]         ID_STAT    = 8'hE0,
  parameter logic [7:0]         ID_XFEAT   = 8'h39,
  parameter logic [7:0]         ID_L2      = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [CPU_AW-1:0]  cpu_addr,
  output logic               io_hit,
  output logic [APER_AW-1:0] io_port,
  output logic               rst_req,
  output logic               light
);
  localparam int PAGE_W   = APER_AW - PAGE_LSB;
  localparam int SPARSE_W = PAGE_W + SPARSE_LOW;
  localparam logic [REG_AW-1:0] A_CPUCFG = CTRL_BASE;
  localparam logic [REG_AW-1:0] A_FEAT   = CTRL_BASE + 16'd1;
  localparam logic [REG_AW-1:0] A_STAT   = CTRL_BASE + 16'd2;
  localparam logic [REG_AW-1:0] A_XFEAT  = CTRL_BASE + 16'd3;
  localparam logic [REG_AW-1:0] A_L2     = CTRL_BASE + 16'd4;
  localparam logic [REG_AW-1:0] A_SYSCTL = CTRL_BASE + 16'd8;
  localparam logic [REG_AW-1:0] A_LIGHT  = CTRL_BASE + 16'd9;
  localparam logic [REG_AW-1:0] A_MAP    = CTRL_BASE + 16'd10;

  logic                map_q;
  logic [3:0]          sysctl_q;
  logic [APER_AW-1:0]  offset;
  logic [APER_AW-1:0]  sparse;

  assign offset = cpu_addr[APER_AW-1:0];
  assign io_hit = (cpu_addr[CPU_AW-1:APER_AW] == APER_BASE[CPU_AW-1:APER_AW]);
  assign sparse = {{(APER_AW-SPARSE_W){1'b0}},
                   offset[APER_AW-1:PAGE_LSB], offset[SPARSE_LOW-1:0]};
  assign io_port = !io_hit ? '0 : (map_q ? sparse : offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q    <= 1'b0;
      sysctl_q <= 4'h0;
      rst_req  <= 1'b0;
      light    <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RST_PORT: rst_req  <= reg_wdata[0];
        A_SYSCTL: sysctl_q <= reg_wdata[3:0];
        A_LIGHT:  light    <= reg_wdata[0];
        A_MAP:    map_q    <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RST_PORT: reg_rdata = {7'b0, rst_req};
      A_CPUCFG: reg_rdata = ID_CPUCFG;
      A_FEAT:   reg_rdata = ID_FEAT;
      A_STAT:   reg_rdata = ID_STAT;
      A_XFEAT:  reg_rdata = ID_XFEAT;
      A_L2:     reg_rdata = ID_L2;
      A_SYSCTL: reg_rdata = {4'b0, sysctl_q};
      A_LIGHT:  reg_rdata = {7'b0, light};
      A_MAP:    reg_rdata = {7'b0, map_q};
      default:  reg_rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/io_window_ctl_checks.sv
module io_window_ctl_checks #(
  parameter int                 CPU_AW    = 32,
  parameter int                 APER_AW   = 23,
  parameter logic [CPU_AW-1:0]  APER_BASE = 32'h8000_0000,
  parameter int                 SPARSE_W  = 16,
  parameter int                 REG_AW    = 16,
  parameter logic [REG_AW-1:0]  RST_PORT  = 16'h0092,
  parameter logic [REG_AW-1:0]  A_CPUCFG  = 16'h0800,
  parameter logic [REG_AW-1:0]  A_SYSCTL  = 16'h0808,
  parameter logic [REG_AW-1:0]  A_LIGHT   = 16'h0809,
  parameter logic [REG_AW-1:0]  A_MAP     = 16'h080A,
  parameter logic [7:0]         ID_CPUCFG = 8'hEF
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REG_AW-1:0]  reg_addr,
  input logic               reg_we,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic               io_hit,
  input logic [APER_AW-1:0] io_port,
  input logic               rst_req,
  input logic               light,
  input logic               map_q,
  input logic [3:0]         sysctl_q
);
  p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1:APER_AW] != APER_BASE[CPU_AW-1:APER_AW]) |-> (!io_hit && io_port == '0));

  p_sparse_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && map_q) |-> ((io_port >> SPARSE_W) == '0));

  p_map_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_MAP) |=> (map_q == $past(reg_wdata[0])));

  p_sysctl_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SYSCTL) |=> (sysctl_q == $past(reg_wdata[3:0])));

  p_rst_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RST_PORT) |=> (rst_req == $past(reg_wdata[0])));

  p_light_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_LIGHT) |=> (light == $past(reg_wdata[0])));

  p_id_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CPUCFG) |-> (reg_rdata == ID_CPUCFG));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(map_q) && $stable(sysctl_q) && $stable(rst_req) && $stable(light)));
endmodule

bind io_window_ctl io_window_ctl_checks #(
  .CPU_AW(CPU_AW), .APER_AW(APER_AW), .APER_BASE(APER_BASE), .SPARSE_W(SPARSE_W),
  .REG_AW(REG_AW), .RST_PORT(RST_PORT), .A_CPUCFG(A_CPUCFG), .A_SYSCTL(A_SYSCTL),
  .A_LIGHT(A_LIGHT), .A_MAP(A_MAP), .ID_CPUCFG(ID_CPUCFG)
) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
  .io_hit(io_hit), .io_port(io_port), .rst_req(rst_req), .light(light),
  .map_q(map_q), .sysctl_q(sysctl_q)
);

// File: tb/io_window_ctl_test.sv
`timescale 1ns/1ps
module io_window_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        io_hit;
  logic [22:0] io_port;
  logic        rst_req;
  logic        light;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  io_window_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .io_hit(io_hit), .io_port(io_port), .rst_req(rst_req), .light(light)
  );

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {24'b0, reg_rdata};
        1: act = {8'b0, io_hit, io_port};
        2: act = {31'b0, rst_req};
        default: act = {31'b0, light};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = 0; it.exp = {24'b0, e}; it.tag = tag;
    sb.push_back(it);
    step();
  endtask

  task automatic pin(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    step();
  endtask

  function automatic logic [23:0] exp_io(input logic [31:0] a, input bit sparse);
    logic [31:0] off;
    if (a < 32'h8000_0000 || a >= 32'h8080_0000) return 24'h0;
    off = a - 32'h8000_0000;
    if (sparse) off = (off & 32'h1F) | ((off & 32'h7FF000) >> 7);
    return {1'b1, off[22:0]};
  endfunction

  task automatic io(input logic [31:0] a, input bit sparse, input string tag);
    item_t it;
    cpu_addr = a;
    it.kind = 1; it.exp = {8'b0, exp_io(a, sparse)}; it.tag = tag;
    sb.push_back(it);
    step();
  endtask

  task automatic regs_intact(input logic [7:0] sc, input logic lt, input logic rr,
                             input logic mp, input string tag);
    rd(16'h0808, {4'b0, sc[3:0]}, tag);
    rd(16'h0809, {7'b0, lt}, tag);
    rd(16'h0092, {7'b0, rr}, tag);
    rd(16'h080A, {7'b0, mp}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    regs_intact(8'h00, 1'b0, 1'b0, 1'b0, "R11 reset");
    pin(2, 1'b0, "R11 rst_req");
    pin(3, 1'b0, "R11 light");

    rd(16'h0800, 8'hEF, "R8 cpu cfg");
    rd(16'h0801, 8'hAD, "R8 features");
    rd(16'h0802, 8'hE0, "R8 status");
    rd(16'h0803, 8'h39, "R8 ext features");
    rd(16'h0804, 8'h03, "R8 l2 status");

    rd(16'h0805, 8'hFF, "R9 undecoded");
    rd(16'h0000, 8'hFF, "R9 undecoded");
    rd(16'h0093, 8'hFF, "R9 undecoded");
    rd(16'hFFFF, 8'hFF, "R9 undecoded");

    wr(16'h0808, 8'hA5);
    rd(16'h0808, 8'h05, "R5 sysctl low nibble");
    wr(16'h0808, 8'hFF);
    rd(16'h0808, 8'h0F, "R5 sysctl all ones");

    wr(16'h0809, 8'h01);
    pin(3, 1'b1, "R7 light on");
    rd(16'h0809, 8'h01, "R7 light read");
    wr(16'h0809, 8'hFE);
    pin(3, 1'b0, "R7 light off");
    wr(16'h0809, 8'h81);

    wr(16'h0092, 8'h03);
    pin(2, 1'b1, "R6 reset request on");
    rd(16'h0092, 8'h01, "R6 port read");
    wr(16'h0092, 8'h02);
    pin(2, 1'b0, "R6 reset request off");

    wr(16'h0805, 8'h00);
    wr(16'h080B, 8'hFF);
    wr(16'h0000, 8'h00);
    regs_intact(8'h0F, 1'b1, 1'b0, 1'b0, "R9 undecoded write");

    wr(16'h0800, 8'h00);
    wr(16'h0804, 8'hFF);
    rd(16'h0800, 8'hEF, "R10 id write ignored");
    rd(16'h0804, 8'h03, "R10 id write ignored");
    regs_intact(8'h0F, 1'b1, 1'b0, 1'b0, "R10 no side effect");

    io(32'h8000_03F8, 0, "R2 contiguous");
    io(32'h8000_FFFF, 0, "R2 contiguous");
    io(32'h8012_3456, 0, "R2 contiguous");
    io(32'h8000_0000, 0, "R1 aperture low edge");
    io(32'h807F_FFFF, 0, "R1 aperture high edge");
    io(32'h7FFF_FFFF, 0, "R1 below aperture");
    io(32'h8080_0000, 0, "R1 above aperture");
    io(32'h0000_1000, 0, "R1 far miss");

    wr(16'h080A, 8'hFF);
    io(32'h8001_F01F, 1, "R12 sparse on next access");
    rd(16'h080A, 8'h01, "R4 map bit read");
    io(32'h8000_3008, 1, "R3 sparse");
    io(32'h807F_F01F, 1, "R3 sparse top");
    io(32'h8055_5FE3, 1, "R3 sparse mixed");
    io(32'h8080_0010, 1, "R1 sparse miss");

    wr(16'h080A, 8'h02);
    io(32'h8001_F01F, 0, "R12 contiguous on next access");
    rd(16'h080A, 8'h00, "R4 map bit cleared");

    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule